// File: doc/BRIEF.md
# Host and Controller Mailbox Pair with Interrupt Signalling

This block lets a system host and an embedded controller pass single bytes to each other. Each side has its own simple register bus, with a write enable, a read enable, an address and data. The host owns an inbound-to-controller mailbox byte. Every host write to it sends a one-cycle interrupt pulse to the controller. The controller owns an outbound-to-host mailbox byte. A controller write to it sets a source bit that can raise the host's software event. The controller can also set further source bits directly.

The host sees a source register that shows which conditions are pending. It also sees a mask register that gates each source bit before all of them are ORed into one registered event line. Pending conditions are cleared in two ways: the host reads the outbound mailbox, or the host writes ones to the source register. A separate registered output reports when neither bus carried a transaction in the previous cycle, so the block may enter low-power mode.

Host register offsets are 0 for the inbound mailbox (read/write), 1 for the outbound mailbox (read only), 2 for the source register and 3 for the mask register. Controller offsets are 0 for the outbound mailbox (write; a read returns the inbound mailbox) and 1 for event-set (write; a read returns the outbound mailbox).

Top module: `emb_mbox`

## Requirements
- R1: A host write at offset 0 stores the byte. The stored byte is returned on ctlRdData when ctlAddr is 0, and on hostRdData at offset 0, from the next cycle on.
- R2: ctlIrq is high for exactly the cycle after each host write at offset 0, including a write of an unchanged value. It is low after every other cycle.
- R3: A controller write at ctlAddr 0 stores the byte as the outbound mailbox, which the host reads at offset 1. The same write sets source bit 0.
- R4: A controller write at ctlAddr 1 sets every source bit k (1 to NUM_SRC-1) whose data bit k is 1. Data bit 0 is ignored. The host reads the source register at offset 2, and bits at and above NUM_SRC read 0.
- R5: A host read at offset 1, with hostRdEn high, clears source bit 0 and leaves the outbound mailbox byte unchanged.
- R6: A host write at offset 2 clears each source bit whose data bit is 1. When data bit 0 is 1, it also clears the outbound mailbox byte to zero.
- R7: When a controller set meets a host clear of the same source bit in one cycle, the bit ends set. A controller write at ctlAddr 0 also keeps its new mailbox byte.
- R8: The mask register at offset 3 is read/write in its low NUM_SRC bits. A 1 blocks that source. Out of reset all NUM_SRC mask bits are 1.
- R9: hostEvent equals the OR over all bits of (source AND NOT mask), as those stood in the previous cycle.
- R10: Out of reset both mailboxes and all source bits are zero, ctlIrq and hostEvent are low, and lowPower is high.
- R11: lowPower is high in the cycle after a cycle with no enable asserted on either bus. It is low in the cycle after any enable was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 2 | Host register offset |
| hostWrData | input | DATA_W | Host write byte |
| hostRdData | output | DATA_W | Host read byte (combinational) |
| ctlWrEn | input | 1 | Controller write strobe |
| ctlRdEn | input | 1 | Controller read strobe |
| ctlAddr | input | 1 | Controller register offset |
| ctlWrData | input | DATA_W | Controller write byte |
| ctlRdData | output | DATA_W | Controller read byte (combinational) |
| ctlIrq | output | 1 | Pulse to the controller per host mailbox write |
| hostEvent | output | 1 | Masked, ORed host software event |
| lowPower | output | 1 | Idle indication |

## Verification
The collision that matters is a controller write that sets a source bit landing in the same cycle as a host action that clears it. The host action is either a read of the outbound mailbox or a write of ones to the source register. The bench provokes both pairings on purpose with fixed bytes. It then reads the source register and the outbound mailbox in the next cycle, and expects the bit set and the new byte kept. Random traffic on both buses produces further collisions, and a bench model that applies clears before sets judges every read and output each cycle.

// File: rtl/emb_mbox_pkg.sv
package emb_mbox_pkg;
  localparam logic [1:0] H_INBOX  = 2'd0;
  localparam logic [1:0] H_OUTBOX = 2'd1;
  localparam logic [1:0] H_SRC    = 2'd2;
  localparam logic [1:0] H_MASK   = 2'd3;
  localparam logic       C_OUTBOX = 1'b0;
  localparam logic       C_EVTSET = 1'b1;

  typedef struct packed {
    logic hostWrInbox;
    logic hostRdOutbox;
    logic hostWrSrc;
    logic hostWrMask;
    logic ctlWrOutbox;
    logic ctlWrEvt;
  } mboxStb_t;
endpackage

// File: rtl/emb_mbox_ctrl.sv
module emb_mbox_ctrl
  import emb_mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic [1:0] hostAddr,
  input  logic       ctlWrEn,
  input  logic       ctlRdEn,
  input  logic       ctlAddr,
  output mboxStb_t   stb,
  output logic       ctlIrq,
  output logic       lowPower
);
  logic anyAccess;

  always_comb begin
    stb.hostWrInbox  = hostWrEn && (hostAddr == H_INBOX);
    stb.hostRdOutbox = hostRdEn && (hostAddr == H_OUTBOX);
    stb.hostWrSrc    = hostWrEn && (hostAddr == H_SRC);
    stb.hostWrMask   = hostWrEn && (hostAddr == H_MASK);
    stb.ctlWrOutbox  = ctlWrEn  && (ctlAddr == C_OUTBOX);
    stb.ctlWrEvt     = ctlWrEn  && (ctlAddr == C_EVTSET);
    anyAccess        = hostWrEn | hostRdEn | ctlWrEn | ctlRdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlIrq   <= 1'b0;
      lowPower <= 1'b1;
    end else begin
      ctlIrq   <= stb.hostWrInbox;
      lowPower <= !anyAccess;
    end
  end
endmodule

// File: rtl/emb_mbox_dp.sv
module emb_mbox_dp
  import emb_mbox_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  mboxStb_t           stb,
  input  logic [1:0]         hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData,
  input  logic               ctlAddr,
  input  logic [DATA_W-1:0]  ctlWrData,
  output logic [DATA_W-1:0]  ctlRdData,
  output logic               hostEvent,
  output logic [NUM_SRC-1:0] srcBits,
  output logic [NUM_SRC-1:0] maskBits
);
  localparam int PAD = DATA_W - NUM_SRC;

  logic [DATA_W-1:0]  inboxQ, outboxQ;
  logic [NUM_SRC-1:0] srcQ, srcNext, maskQ, evtSet;

  // clears first, sets last: a set in the same cycle wins
  always_comb begin
    evtSet  = {ctlWrData[NUM_SRC-1:1], 1'b0};
    srcNext = srcQ;
    if (stb.hostRdOutbox) srcNext[0] = 1'b0;
    if (stb.hostWrSrc)    srcNext    = srcNext & ~hostWrData[NUM_SRC-1:0];
    if (stb.ctlWrOutbox)  srcNext[0] = 1'b1;
    if (stb.ctlWrEvt)     srcNext    = srcNext | evtSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inboxQ    <= '0;
      outboxQ   <= '0;
      srcQ      <= '0;
      maskQ     <= '1;
      hostEvent <= 1'b0;
    end else begin
      if (stb.hostWrInbox) inboxQ <= hostWrData;
      if (stb.ctlWrOutbox)
        outboxQ <= ctlWrData;
      else if (stb.hostWrSrc && hostWrData[0])
        outboxQ <= '0;
      if (stb.hostWrMask) maskQ <= hostWrData[NUM_SRC-1:0];
      srcQ      <= srcNext;
      hostEvent <= |(srcQ & ~maskQ);
    end
  end

  always_comb begin
    case (hostAddr)
      H_INBOX:  hostRdData = inboxQ;
      H_OUTBOX: hostRdData = outboxQ;
      H_SRC:    hostRdData = {{PAD{1'b0}}, srcQ};
      default:  hostRdData = {{PAD{1'b0}}, maskQ};
    endcase
    ctlRdData = (ctlAddr == C_OUTBOX) ? inboxQ : outboxQ;
  end

  assign srcBits  = srcQ;
  assign maskBits = maskQ;
endmodule

// File: rtl/emb_mbox.sv
module emb_mbox
  import emb_mbox_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              ctlWrEn,
  input  logic              ctlRdEn,
  input  logic              ctlAddr,
  input  logic [DATA_W-1:0] ctlWrData,
  output logic [DATA_W-1:0] ctlRdData,
  output logic              ctlIrq,
  output logic              hostEvent,
  output logic              lowPower
);
  mboxStb_t           stb;
  logic [NUM_SRC-1:0] srcBits, maskBits;

  emb_mbox_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .ctlWrEn(ctlWrEn), .ctlRdEn(ctlRdEn), .ctlAddr(ctlAddr),
    .stb(stb), .ctlIrq(ctlIrq), .lowPower(lowPower)
  );

  emb_mbox_dp #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .ctlAddr(ctlAddr), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .hostEvent(hostEvent), .srcBits(srcBits), .maskBits(maskBits)
  );
endmodule

// File: rtl/emb_mbox_chk.sv
module emb_mbox_chk #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWrEn,
  input logic               hostRdEn,
  input logic [1:0]         hostAddr,
  input logic               ctlWrEn,
  input logic               ctlRdEn,
  input logic               ctlAddr,
  input logic               ctlIrq,
  input logic               hostEvent,
  input logic               lowPower,
  input logic [NUM_SRC-1:0] srcBits,
  input logic [NUM_SRC-1:0] maskBits
);
  // R2
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0) |=> ctlIrq);
  // R2
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && hostAddr == 2'd0) |=> !ctlIrq);
  // R7
  src_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlAddr == 1'b0) |=> srcBits[0]);
  // R9
  event_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (hostEvent == $past(|(srcBits & ~maskBits))));
  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn || hostRdEn || ctlWrEn || ctlRdEn) |=> !lowPower);
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn || hostRdEn || ctlWrEn || ctlRdEn) |=> lowPower);
endmodule

bind emb_mbox emb_mbox_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rstN(rstN),
  .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
  .ctlWrEn(ctlWrEn), .ctlRdEn(ctlRdEn), .ctlAddr(ctlAddr),
  .ctlIrq(ctlIrq), .hostEvent(hostEvent), .lowPower(lowPower),
  .srcBits(srcBits), .maskBits(maskBits)
);

// File: tb/emb_mbox_tb_top.sv
`timescale 1ns/100ps
module emb_mbox_tb_top;
  localparam int DATA_W = 8;
  localparam int NUM_SRC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              hostWrEn = 0, hostRdEn = 0, ctlWrEn = 0, ctlRdEn = 0, ctlAddr = 0;
  logic [1:0]        hostAddr = 0;
  logic [DATA_W-1:0] hostWrData = 0, ctlWrData = 0;
  logic [DATA_W-1:0] hostRdData, ctlRdData;
  logic              ctlIrq, hostEvent, lowPower;

  emb_mbox #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) dut_i (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .ctlWrEn(ctlWrEn), .ctlRdEn(ctlRdEn), .ctlAddr(ctlAddr),
    .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .ctlIrq(ctlIrq), .hostEvent(hostEvent), .lowPower(lowPower)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DATA_W-1:0]  mInbox = 0, mOutbox = 0;
  logic [NUM_SRC-1:0] mSrc = 0, mMask = '1;
  logic eIrq = 0, eEvt = 0, eLp = 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] hostView(input logic [1:0] a);
    case (a)
      2'd0:    return mInbox;
      2'd1:    return mOutbox;
      2'd2:    return {{(DATA_W-NUM_SRC){1'b0}}, mSrc};
      default: return {{(DATA_W-NUM_SRC){1'b0}}, mMask};
    endcase
  endfunction

  function automatic string hostTag(input logic [1:0] a);
    case (a)
      2'd0:    return "R1 host inbox read";
      2'd1:    return "R3 outbox read";
      2'd2:    return "R4 source read";
      default: return "R8 mask read";
    endcase
  endfunction

  task automatic step(input logic hwe, input logic hre, input logic [1:0] ha,
                      input logic [7:0] hwd, input logic cwe, input logic cre,
                      input logic ca, input logic [7:0] cwd);
    logic [NUM_SRC-1:0] ns;
    @(negedge clk);
    hostWrEn = hwe; hostRdEn = hre; hostAddr = ha; hostWrData = hwd;
    ctlWrEn = cwe; ctlRdEn = cre; ctlAddr = ca; ctlWrData = cwd;
    #1;
    chk("R2 ctlIrq", ctlIrq, eIrq);
    chk("R9 hostEvent", hostEvent, eEvt);
    chk("R11 lowPower", lowPower, eLp);
    chk(hostTag(ha), hostRdData, hostView(ha));
    chk("R1 ctl read", ctlRdData, ca ? mOutbox : mInbox);
    // next-cycle expectations
    eIrq = hwe && ha == 2'd0;
    eEvt = |(mSrc & ~mMask);
    eLp  = !(hwe || hre || cwe || cre);
    ns = mSrc;
    if (hre && ha == 2'd1) ns[0] = 1'b0;
    if (hwe && ha == 2'd2) ns = ns & ~hwd[NUM_SRC-1:0];
    if (cwe && !ca) ns[0] = 1'b1;
    if (cwe && ca)  ns = ns | {cwd[NUM_SRC-1:1], 1'b0};
    if (hwe && ha == 2'd0) mInbox = hwd;
    if (cwe && !ca) mOutbox = cwd;
    else if (hwe && ha == 2'd2 && hwd[0]) mOutbox = '0;
    if (hwe && ha == 2'd3) mMask = hwd[NUM_SRC-1:0];
    mSrc = ns;
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    step(0, 0, a, 8'h00, 0, 0, 0, 8'h00);
    chk(tag, hostRdData, exp);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 reset state, observed during and right after reset
    chk("R10 ctlIrq", ctlIrq, 0);
    chk("R10 hostEvent", hostEvent, 0);
    chk("R10 lowPower", lowPower, 1);
    rstN = 1'b1;
    peek(2'd2, 8'h00, "R10 source zero");
    peek(2'd3, 8'h0F, "R8 mask reset");
    peek(2'd0, 8'h00, "R10 inbox zero");
    peek(2'd1, 8'h00, "R10 outbox zero");

    // R2: same value written twice pulses twice
    step(1, 0, 2'd0, 8'h5A, 0, 0, 0, 8'h00);
    step(1, 0, 2'd0, 8'h5A, 0, 0, 0, 8'h00);
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 8'h00);
    chk("R2 second pulse", ctlIrq, 1);

    // R3, R9: outbox write, unmask bit0
    step(0, 0, 2'd0, 8'h00, 1, 0, 0, 8'h3C);
    step(1, 0, 2'd3, 8'h0E, 0, 0, 0, 8'h00);
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 8'h00);
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 8'h00);
    chk("R9 event unmasked", hostEvent, 1);

    // R5: read clears bit0, byte kept
    step(0, 1, 2'd1, 8'h00, 0, 0, 0, 8'h00);
    peek(2'd2, 8'h00, "R5 source cleared by read");
    peek(2'd1, 8'h3C, "R5 outbox kept");

    // R7: set against read-clear
    step(0, 1, 2'd1, 8'h00, 1, 0, 0, 8'h77);
    peek(2'd2, 8'h01, "R7 set beats read clear");
    // R7: set against write-one-clear
    step(1, 0, 2'd2, 8'h01, 1, 0, 0, 8'h11);
    peek(2'd2, 8'h01, "R7 set beats W1C");
    peek(2'd1, 8'h11, "R7 new byte kept");
    // R6: W1C clears bit and outbox
    step(1, 0, 2'd2, 8'h01, 0, 0, 0, 8'h00);
    peek(2'd2, 8'h00, "R6 source cleared");
    peek(2'd1, 8'h00, "R6 outbox zeroed");

    // R4: event set, bit0 of data ignored
    step(0, 0, 2'd0, 8'h00, 1, 0, 1, 8'hFF);
    peek(2'd2, 8'h0E, "R4 event bits set");
    step(1, 0, 2'd2, 8'h04, 0, 0, 0, 8'h00);
    peek(2'd2, 8'h0A, "R6 partial clear");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int hop, cop;
      hop = $urandom_range(0, 3);
      cop = $urandom_range(0, 4);
      step(hop == 1, hop == 2, 2'($urandom_range(0, 3)), 8'($urandom),
           cop == 1 || cop == 2, cop == 3, 1'($urandom_range(0, 1)), 8'($urandom));
    end
    step(0, 0, 2'd0, 8'h00, 0, 0, 0, 8'h00);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule